// File: doc/BRIEF.md
# Auto-Precharge Command Spacing Checker

This block watches a decoded DRAM command stream, one command per clock, and enforces the minimum spacing between a read or write that carries auto-precharge and a later command aimed at a different bank. It holds exactly one tracked source command, which is the most recent auto-precharge access. It counts the clocks since that command. Each incoming command is judged against the gap that applies to its class, and the block raises a violation flag in the same cycle as the offending command.

The required gap depends on the type of the source command and on the class of the target command. A write source that is followed by a read pays the CAS latency less one, plus half the burst, plus the write-to-read turnaround. The other read and write pairings depend on half the burst. Single-bank precharge and activate need one clock. A precharge-all is refused for as long as the source is tracked. One ready output per command class tells a scheduler whether a command of that class, sent to another bank, would be accepted in the current cycle.

Configuration is static while traffic flows. The CAS latency is 3 to 6, the burst length is 4 or 8, and the write-to-read turnaround is a 3-bit clock count.

Top module: `ap_gap_checker`

## Requirements
- R1: After reset nothing is tracked, `viol_o` is 0 and all four ready outputs are 1.
- R2: After a write with auto-precharge (cmd 3, ap 1), a read (cmd 2, any ap) to another bank is flagged when its distance in clocks is below (CL-1)+BL/2+tWTR. BL/2 is 4 when `cfg_bl8_i`=1 and 2 when it is 0.
- R3: After a write with auto-precharge, a write (cmd 3) to another bank is flagged when its distance is below BL/2.
- R4: After a read with auto-precharge (cmd 2, ap 1), a read to another bank is flagged when its distance is below BL/2.
- R5: After a read with auto-precharge, a write to another bank is flagged when its distance is below BL/2+2.
- R6: An activate (cmd 1) or a single-bank precharge (cmd 4) to another bank is legal from distance 1 onward.
- R7: A precharge-all (cmd 5) is flagged whenever a source is tracked, whatever the bank input.
- R8: A NOP (cmd 0), refresh or reserved code (6, 7), or any command other than cmd 5 aimed at the tracked bank, is never flagged.
- R9: Every read or write with auto-precharge becomes the new tracked source and restarts the distance at 1 on the next clock. This holds even if that command was itself flagged against the previous source.
- R10: Tracking ends once the distance reaches the longest gap of the source. That gap is the R2 gap for a write source and BL/2+2 for a read source. From that point every command is legal and all ready outputs are 1.
- R11: `viol_o` is combinational in the cycle of the command. `legal_o` is 1 for any non-NOP command that is not flagged. Each ready output is 1 exactly when a command of its class to another bank would not be flagged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA, 6/7 unchecked |
| bank_i | input | BANK_W | Target bank of the command |
| ap_i | input | 1 | Auto-precharge flag on RD/WR |
| cfg_cl_i | input | CL_W | CAS latency in clocks (3..6) |
| cfg_bl8_i | input | 1 | 1 selects burst 8, 0 selects burst 4 |
| cfg_twtr_i | input | TWTR_W | Write-to-read turnaround in clocks |
| viol_o | output | 1 | Current command breaks a spacing rule |
| legal_o | output | 1 | Current command is non-NOP and not flagged |
| rdy_rd_o | output | 1 | Read to another bank is allowed now |
| rdy_wr_o | output | 1 | Write to another bank is allowed now |
| rdy_bank_o | output | 1 | Activate or single-bank precharge to another bank is allowed now |
| rdy_prea_o | output | 1 | Precharge-all is allowed now |

## Verification
The judging path and the tracking path can act on the same command. An auto-precharge access that arrives too early against the current source is both flagged and adopted as the new source in that cycle. The bench provokes this with a read with auto-precharge followed two clocks later by a write with auto-precharge to another bank. It checks that the violation appears in that cycle. It then checks that later reads are measured from the new write source against the write-to-read gap, one clock short and then exactly on time, and that a same-bank read right after the replacement is not flagged.

// File: rtl/ap_gap_pkg.sv
package ap_gap_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_RSV  = 3'd7
  } cmd_e;

  function automatic int max_gap(input int cl_w, input int twtr_w);
    return ((1 << cl_w) - 2) + 4 + ((1 << twtr_w) - 1);
  endfunction
endpackage

// File: rtl/ap_gap_calc.sv
module ap_gap_calc #(
  parameter int CL_W   = 3,
  parameter int TWTR_W = 3,
  parameter int GAP_W  = 5
) (
  input  logic [CL_W-1:0]   cl_i,
  input  logic              bl8_i,
  input  logic [TWTR_W-1:0] twtr_i,
  input  logic              src_wr_i,
  output logic [GAP_W-1:0]  gap_rd_o,
  output logic [GAP_W-1:0]  gap_wr_o,
  output logic [GAP_W-1:0]  gap_bank_o,
  output logic [GAP_W-1:0]  span_o
);
  logic [GAP_W-1:0] half_bl, wr2rd, rd2wr;

  always_comb begin
    half_bl = bl8_i ? GAP_W'(4) : GAP_W'(2);
    wr2rd   = GAP_W'(cl_i) - GAP_W'(1) + half_bl + GAP_W'(twtr_i);
    rd2wr   = half_bl + GAP_W'(2);
  end

  always_comb begin
    gap_bank_o = GAP_W'(1);
    if (src_wr_i) begin
      gap_rd_o = wr2rd;
      gap_wr_o = half_bl;
      span_o   = wr2rd;
    end else begin
      gap_rd_o = half_bl;
      gap_wr_o = rd2wr;
      span_o   = rd2wr;
    end
  end
endmodule

// File: rtl/ap_gap_tracker.sv
module ap_gap_tracker
  import ap_gap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int GAP_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic [GAP_W-1:0]  span_i,
  output logic              active_o,
  output logic              src_wr_o,
  output logic [BANK_W-1:0] src_bank_o,
  output logic [GAP_W-1:0]  cnt_o
);
  logic start;
  logic [GAP_W:0] cnt_nx;

  assign start  = ap_i && (cmd_i == CMD_RD || cmd_i == CMD_WR);
  assign cnt_nx = {1'b0, cnt_o} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      src_wr_o   <= 1'b0;
      src_bank_o <= '0;
      cnt_o      <= '0;
    end else if (start) begin
      active_o   <= 1'b1;
      src_wr_o   <= (cmd_i == CMD_WR);
      src_bank_o <= bank_i;
      cnt_o      <= GAP_W'(1);
    end else if (active_o) begin
      if (cnt_nx >= {1'b0, span_i}) begin
        active_o <= 1'b0;
        cnt_o    <= '0;
      end else begin
        cnt_o <= cnt_nx[GAP_W-1:0];
      end
    end
  end

  AST_CNT_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (cnt_o >= GAP_W'(1) && cnt_o < span_i)); // R10
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (active_o && cnt_o == GAP_W'(1))); // R9
  AST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start && cnt_nx >= {1'b0, span_i}) |=> !active_o); // R10
endmodule

// File: rtl/ap_gap_judge.sv
module ap_gap_judge
  import ap_gap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int GAP_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              active_i,
  input  logic [BANK_W-1:0] src_bank_i,
  input  logic [GAP_W-1:0]  cnt_i,
  input  logic [GAP_W-1:0]  gap_rd_i,
  input  logic [GAP_W-1:0]  gap_wr_i,
  input  logic [GAP_W-1:0]  gap_bank_i,
  output logic              viol_o,
  output logic              legal_o,
  output logic              rdy_rd_o,
  output logic              rdy_wr_o,
  output logic              rdy_bank_o,
  output logic              rdy_prea_o
);
  logic other_bank;

  always_comb begin
    rdy_rd_o   = !active_i || (cnt_i >= gap_rd_i);
    rdy_wr_o   = !active_i || (cnt_i >= gap_wr_i);
    rdy_bank_o = !active_i || (cnt_i >= gap_bank_i);
    rdy_prea_o = !active_i;
  end

  assign other_bank = (bank_i != src_bank_i);

  always_comb begin
    unique case (cmd_i)
      CMD_RD:           viol_o = other_bank && !rdy_rd_o;
      CMD_WR:           viol_o = other_bank && !rdy_wr_o;
      CMD_ACT, CMD_PRE: viol_o = other_bank && !rdy_bank_o;
      CMD_PREA:         viol_o = !rdy_prea_o;
      default:          viol_o = 1'b0;
    endcase
    legal_o = (cmd_i != CMD_NOP) && !viol_o;
  end

  AST_PREA_BAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cmd_i == CMD_PREA) |-> viol_o); // R7
  AST_SAME_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_PREA && bank_i == src_bank_i) |-> !viol_o); // R8
  AST_QUIET_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP || cmd_i == CMD_REF || cmd_i == CMD_RSV) |-> !viol_o); // R8
endmodule

// File: rtl/ap_gap_checker.sv
module ap_gap_checker
  import ap_gap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CL_W   = 3,
  parameter int TWTR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic [CL_W-1:0]   cfg_cl_i,
  input  logic              cfg_bl8_i,
  input  logic [TWTR_W-1:0] cfg_twtr_i,
  output logic              viol_o,
  output logic              legal_o,
  output logic              rdy_rd_o,
  output logic              rdy_wr_o,
  output logic              rdy_bank_o,
  output logic              rdy_prea_o
);
  localparam int MAX_GAP = max_gap(CL_W, TWTR_W);
  localparam int GAP_W   = $clog2(MAX_GAP + 1);

  cmd_e              cmd;
  logic              active, src_wr;
  logic [BANK_W-1:0] src_bank;
  logic [GAP_W-1:0]  cnt, gap_rd, gap_wr, gap_bank, span;

  assign cmd = cmd_e'(cmd_i);

  ap_gap_calc #(.CL_W(CL_W), .TWTR_W(TWTR_W), .GAP_W(GAP_W)) u_calc (
    .cl_i(cfg_cl_i), .bl8_i(cfg_bl8_i), .twtr_i(cfg_twtr_i), .src_wr_i(src_wr),
    .gap_rd_o(gap_rd), .gap_wr_o(gap_wr), .gap_bank_o(gap_bank), .span_o(span)
  );

  ap_gap_tracker #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_track (
    .clk_i, .rst_ni, .cmd_i(cmd), .bank_i, .ap_i, .span_i(span),
    .active_o(active), .src_wr_o(src_wr), .src_bank_o(src_bank), .cnt_o(cnt)
  );

  ap_gap_judge #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_judge (
    .clk_i, .rst_ni, .cmd_i(cmd), .bank_i, .active_i(active),
    .src_bank_i(src_bank), .cnt_i(cnt), .gap_rd_i(gap_rd), .gap_wr_i(gap_wr),
    .gap_bank_i(gap_bank), .viol_o, .legal_o, .rdy_rd_o, .rdy_wr_o,
    .rdy_bank_o, .rdy_prea_o
  );

  AST_RD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && cmd == CMD_RD) |-> !rdy_rd_o); // R11
  AST_WR_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && cmd == CMD_WR) |-> !rdy_wr_o); // R11
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (rdy_rd_o && rdy_wr_o && rdy_bank_o && rdy_prea_o && !viol_o)); // R10
endmodule

// File: tb/ap_gap_checker_tb.sv
module ap_gap_checker_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] bank_i = 2'd0;
  logic       ap_i = 1'b0;
  logic [2:0] cfg_cl_i = 3'd4;
  logic       cfg_bl8_i = 1'b1;
  logic [2:0] cfg_twtr_i = 3'd2;
  logic viol_o, legal_o, rdy_rd_o, rdy_wr_o, rdy_bank_o, rdy_prea_o;
  int checks = 0, errors = 0;

  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, REF = 6;

  always #5 clk_i = ~clk_i;

  ap_gap_checker dut_i (.*);

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic a);
    @(negedge clk_i);
    cmd_i = c; bank_i = b; ap_i = a;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(NOP, 2'd0, 1'b0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    step(NOP, 0, 0);
    chk(viol_o, 0, "R1 viol");
    chk(rdy_rd_o && rdy_wr_o && rdy_bank_o && rdy_prea_o, 1, "R1 ready");
    rst_ni = 1'b1;
  endtask

  // source, then probe one short of gap and exactly at gap
  task automatic t_gap(input logic [2:0] src, input logic [2:0] probe, input int gap, input string tag);
    step(src, 2'd0, 1'b1);
    if (gap > 2) idle(gap - 2);
    if (gap > 1) begin
      step(probe, 2'd1, 1'b0);
      chk(viol_o, 1, {tag, " early viol"});
      chk(legal_o, 0, {tag, " early legal"});
      if (probe == RD) chk(rdy_rd_o, 0, {tag, " early rdy"});
      if (probe == WR) chk(rdy_wr_o, 0, {tag, " early rdy"});
    end
    step(probe, 2'd1, 1'b0);
    chk(viol_o, 0, {tag, " on-time viol"});
    chk(legal_o, 1, {tag, " on-time legal"});
    idle(12);
  endtask

  task automatic t_bank_cmds;
    step(WR, 2'd0, 1'b1);
    step(ACT, 2'd2, 1'b0);
    chk(viol_o, 0, "R6 act dist1");
    chk(rdy_bank_o, 1, "R6 rdy_bank");
    step(PRE, 2'd3, 1'b0);
    chk(viol_o, 0, "R6 pre dist2");
    idle(12);
  endtask

  task automatic t_prea_and_end;
    step(WR, 2'd0, 1'b1);           // span 9
    step(PREA, 2'd0, 1'b0);
    chk(viol_o, 1, "R7 prea dist1");
    chk(rdy_prea_o, 0, "R7 rdy_prea");
    idle(6);
    step(PREA, 2'd1, 1'b0);         // dist 8
    chk(viol_o, 1, "R7 prea dist8");
    step(PREA, 2'd1, 1'b0);         // dist 9
    chk(viol_o, 0, "R10 prea after window");
    chk(rdy_rd_o && rdy_wr_o && rdy_bank_o && rdy_prea_o, 1, "R10 all ready");
    idle(2);
  endtask

  task automatic t_quiet;
    step(RD, 2'd2, 1'b1);
    step(WR, 2'd2, 1'b0);
    chk(viol_o, 0, "R8 same bank wr");
    step(REF, 2'd1, 1'b0);
    chk(viol_o, 0, "R8 refresh");
    step(NOP, 2'd1, 1'b0);
    chk(viol_o, 0, "R8 nop");
    chk(legal_o, 0, "R11 nop not legal");
    idle(10);
  endtask

  task automatic t_replace;
    step(RD, 2'd0, 1'b1);
    idle(1);
    step(WR, 2'd1, 1'b1);           // dist 2 < 6
    chk(viol_o, 1, "R9 replacing cmd flagged");
    step(RD, 2'd1, 1'b0);
    chk(viol_o, 0, "R9 same bank as new src");
    idle(6);
    step(RD, 2'd0, 1'b0);           // dist 8 < 9
    chk(viol_o, 1, "R9 measured from new src");
    step(RD, 2'd0, 1'b0);           // dist 9
    chk(viol_o, 0, "R9 new src gap met");
    idle(12);
  endtask

  initial begin
    fork
      begin
        t_reset;
        // CL4 BL8 tWTR2: wr->rd 9, wr->wr 4, rd->rd 4, rd->wr 6
        t_gap(WR, RD, 9, "R2");
        t_gap(WR, WR, 4, "R3");
        t_gap(RD, RD, 4, "R4");
        t_gap(RD, WR, 6, "R5");
        t_bank_cmds;
        t_prea_and_end;
        t_quiet;
        t_replace;
        // CL3 BL4 tWTR0: wr->rd 4, rd->wr 4, rd->rd 2
        cfg_cl_i = 3'd3; cfg_bl8_i = 1'b0; cfg_twtr_i = 3'd0;
        t_gap(WR, RD, 4, "R2 cfg2");
        t_gap(RD, WR, 4, "R5 cfg2");
        t_gap(RD, RD, 2, "R4 cfg2");
        // CL6 BL8 tWTR7: wr->rd 16
        cfg_cl_i = 3'd6; cfg_bl8_i = 1'b1; cfg_twtr_i = 3'd7;
        t_gap(WR, RD, 16, "R2 cfg3");
      end
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule